// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Cascade Enables

A small counting stage that advances by one on each rising clock edge while two enables are both high. One of them, the parallel enable, is meant to be shared across many stages. The other, the trickle enable, also gates a terminal-count flag. The stage can be preset from a data input, cleared by an active-low reset, or left holding its value. Chaining the terminal-count flag of one stage into the trickle enable of the next builds a wider counter that stays fully synchronous.

A parameter picks the reset style. With asynchronous clear, the count and the flag drop as soon as reset goes low. With synchronous clear, reset acts only on the next rising edge. In that mode the count can be decoded back into the reset input to shorten the counting cycle.

Top module: `cascade_counter`

## Requirements
- R1: With SYNC clear selected (ASYNC_CLR = 0), a low `rst_n` at a rising edge makes `count` zero after that edge, whatever `load_n`, `en_par` and `en_trk` are.
- R2: With asynchronous clear selected (ASYNC_CLR = 1), a low `rst_n` forces `count` to zero and `tc` low at once, with no clock edge.
- R3: With `rst_n` high and `load_n` low at a rising edge, `count` takes the value of `din` on that edge, whatever the levels on both enables.
- R4: When `rst_n` and `load_n` are both low at the same edge, clearing wins and `count` becomes zero.
- R5: With `rst_n` and `load_n` high and both `en_par` and `en_trk` high, `count` goes up by one on the edge.
- R6: With `rst_n` and `load_n` high and either enable low, `count` keeps its value.
- R7: An enabled count from all ones (15 at the default width) wraps to zero.
- R8: `tc` is high exactly when `en_trk` is high and `count` is all ones. It follows `en_trk` combinationally, and `en_par` has no effect on it.
- R9: Two stages built this way count as one synchronous 8-bit counter. The low stage's `tc` drives the high stage's `en_trk`, and one line drives both `en_par` inputs.
- R10: In SYNC clear mode, feeding `count == 6` into `rst_n` makes the count run 0,1,...,6,0 with period 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset |
| din | input | WIDTH | Preset value |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `tc` |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
The hardest states to reach from the ports are the ones only seen in a chain. The high stage of a two-stage chain moves only on the single edge where the low stage sits at 15 with the shared enable high. The stimulus therefore runs the chain through hundreds of edges to the all-ones state of both stages and then across the wrap. It also pauses the shared enable in between, so that holding is tested as well. Two other cases are checked without any clock edge in between: the asynchronous clear, and a trickle-enable toggle at count 15. For these the inputs change mid-cycle and the outputs are sampled before the next rising edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        M_CLR  = 2'd0,
        M_LOAD = 2'd1,
        M_INC  = 2'd2,
        M_HOLD = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import cnt_pkg::*;
(
    input  logic      rst_n,
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output cnt_mode_e mode
);
    // Fixed priority: clear, preset, advance, hold.
    always_comb begin
        if (!rst_n)                 mode = M_CLR;
        else if (!load_n)           mode = M_LOAD;
        else if (en_par && en_trk)  mode = M_INC;
        else                        mode = M_HOLD;
    end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt_d
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            M_CLR:   cnt_d = '0;
            M_LOAD:  cnt_d = din;
            M_INC:   cnt_d = cnt_q + ONE;   // natural wrap at all ones
            default: cnt_d = cnt_q;
        endcase
    end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt_q,
    input  logic             en_trk,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TERM = '1;

    always_comb tc = en_trk && (cnt_q == TERM);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] count,
    output logic             tc
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    cnt_mode_e        mode;
    logic [WIDTH-1:0] nxt_cnt;

    cnt_mode_dec u_dec (
        .rst_n  (rst_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .mode   (mode)
    );

    cnt_next #(.WIDTH(WIDTH)) u_next (
        .mode  (mode),
        .cnt_q (st_q.cnt),
        .din   (din),
        .cnt_d (nxt_cnt)
    );

    cnt_tc #(.WIDTH(WIDTH)) u_tc (
        .cnt_q  (st_q.cnt),
        .en_trk (en_trk),
        .tc     (tc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt_cnt;
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_sync
            // Clearing comes through the mode decode on the edge.
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end
    endgenerate

    assign count = st_q.cnt;

    // Terminal count needs the trickle enable and all ones.
    p_tc_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (en_trk && (&count)));

    // Preset takes the data word whatever the enables do.
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n) |=> (count == $past(din)));

    // Both enables high: advance by one, wrapping at all ones (R7).
    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && en_par && en_trk) |=> (count == WIDTH'($past(count) + 1'b1)));

    // Either enable low: hold.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));
endmodule

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
    localparam int W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- main DUT: synchronous clear ----------------
    logic         rst_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc;

    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .count(count), .tc(tc));

    // ---------------- asynchronous-clear DUT ----------------
    logic         a_rst_n = 1'b0, a_load_n = 1'b1, a_en_trk = 1'b0;
    logic [W-1:0] a_din = '0;
    logic [W-1:0] a_count;
    logic         a_tc;

    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) dut_async (
        .clk(clk), .rst_n(a_rst_n), .load_n(a_load_n), .din(a_din),
        .en_par(1'b0), .en_trk(a_en_trk), .count(a_count), .tc(a_tc));

    // ---------------- two-stage chain ----------------
    logic         c_rst_n = 1'b0, c_ep = 1'b0;
    logic [W-1:0] lo_cnt, hi_cnt;
    logic         lo_tc, hi_tc;

    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) cas_lo (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din('0),
        .en_par(c_ep), .en_trk(1'b1), .count(lo_cnt), .tc(lo_tc));
    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) cas_hi (
        .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din('0),
        .en_par(c_ep), .en_trk(lo_tc), .count(hi_cnt), .tc(hi_tc));

    // ---------------- modulo-7 via decoded reset ----------------
    logic         m_rst_n = 1'b0;
    logic [W-1:0] m_cnt;
    logic         m_tc;
    logic         m_clr_n;
    assign m_clr_n = m_rst_n && (m_cnt != W'(6));

    cascade_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) dut_mod (
        .clk(clk), .rst_n(m_clr_n), .load_n(1'b1), .din('0),
        .en_par(1'b1), .en_trk(1'b1), .count(m_cnt), .tc(m_tc));

    // ---------------- scoreboard ----------------
    typedef struct {
        int    cnt;
        int    tcv;
        string req;
    } exp_t;
    exp_t sb_q[$];
    int   model = 0;

    task automatic step(input logic r, input logic l, input int d,
                        input logic ep, input logic et, input string req);
        exp_t e;
        @(negedge clk);
        rst_n = r; load_n = l; din = W'(d); en_par = ep; en_trk = et;
        if (!r)            model = 0;
        else if (!l)       model = d;
        else if (ep && et) model = (model + 1) % (1 << W);
        e.cnt = model;
        e.tcv = (et && model == (1 << W) - 1) ? 1 : 0;
        e.req = req;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.req, " count"}, int'(count), e.cnt);
            check({e.req, " tc"}, int'(tc), e.tcv);
        end
    end

    task automatic c_run(input int n);
        @(negedge clk);
        c_ep = 1'b1;
        repeat (n) @(negedge clk);
        c_ep = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // ---- scoreboard sequence on the synchronous-clear DUT ----
        step(0, 1, 0, 0, 0, "R1 reset state");
        step(0, 0, 5, 1, 1, "R4 clear over preset");
        step(1, 0, 9, 0, 0, "R3 preset enables low");
        step(1, 1, 0, 1, 1, "R5 advance");
        step(1, 1, 0, 1, 1, "R5 advance again");
        step(1, 1, 0, 0, 1, "R6 hold par low");
        step(1, 1, 0, 1, 0, "R6 hold trk low");
        step(1, 0, 14, 1, 1, "R3 preset over count");
        step(1, 1, 0, 1, 1, "R8 reach all ones");
        step(1, 1, 0, 0, 1, "R8 par no effect on tc");
        step(1, 1, 0, 0, 0, "R8 trk low masks tc");
        step(1, 1, 0, 1, 1, "R7 wrap to zero");
        step(1, 0, 3, 0, 0, "R3 preset three");
        step(0, 1, 0, 1, 1, "R1 clear while counting");
        step(1, 0, 15, 0, 0, "R3 preset fifteen");
        step(1, 1, 0, 0, 0, "R6 hold at fifteen");
        @(negedge clk);
        @(negedge clk);
        // R8: combinational tc, no clock edge between toggles
        en_trk = 1'b1;
        #1 check("R8 tc follows trk high", int'(tc), 1);
        en_trk = 1'b0;
        #0.5 check("R8 tc follows trk low", int'(tc), 0);

        // ---- R2: asynchronous clear ----
        @(negedge clk);
        a_rst_n = 1'b1; a_load_n = 1'b0; a_din = 4'd15; a_en_trk = 1'b1;
        @(negedge clk);
        a_load_n = 1'b1;
        check("R2 preset before clear", int'(a_count), 15);
        check("R2 tc before clear", int'(a_tc), 1);
        #0.5 a_rst_n = 1'b0;
        #0.5;
        check("R2 count cleared without edge", int'(a_count), 0);
        check("R2 tc cleared without edge", int'(a_tc), 0);
        @(negedge clk);
        a_rst_n = 1'b1;

        // ---- R9: two-stage chain ----
        @(negedge clk);
        c_rst_n = 1'b1;
        check("R9 chain reset", int'({hi_cnt, lo_cnt}), 0);
        c_run(40);
        check("R9 chain after 40", int'({hi_cnt, lo_cnt}), 40);
        repeat (3) @(negedge clk);
        check("R9 chain holds with shared enable low", int'({hi_cnt, lo_cnt}), 40);
        c_run(215);
        check("R9 chain at 255", int'({hi_cnt, lo_cnt}), 255);
        check("R9 high stage tc", int'(hi_tc), 1);
        c_run(1);
        check("R9 chain wraps", int'({hi_cnt, lo_cnt}), 0);

        // ---- R10: decoded count 6 shortens the cycle ----
        @(negedge clk);
        m_rst_n = 1'b1;
        check("R10 start", int'(m_cnt), 0);
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            check("R10 modulo sequence", int'(m_cnt), i % 7);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule